// File: doc/BRIEF.md
# Serial Controller Register Front End with Receive Queue

This block sits between a simple byte-wide register bus and the byte-level core of an asynchronous serial port. It holds the mode, control, queue-control and port-control registers. It also keeps a status register of sticky flags, queues received bytes in a 16-entry circular buffer, and produces receive and transmit interrupt lines. The bit-level shifter, the baud generator and line-break timing are outside the block. Received bytes arrive as single-cycle valid/data strobes. A detected line break arrives as a one-cycle pulse. Each write to the transmit data register produces a one-cycle valid/data strobe on the output.

Software reads the status register to see the flags, and writes zeros to the flags it wants to clear. While the transmitter is enabled, a status read re-arms the transmit-empty and transmit-end flags after the current value has been returned. Read data is combinational from the address and read strobe. Side effects of a read, such as popping the receive queue or re-arming flags, take place at the clock edge that ends the read cycle. Because the block has no sequencing beyond single-cycle register updates, there is no enumerated state machine.

Register offsets (6-bit address):

| Offset | Register |
|--------|----------|
| 0x00 | mode |
| 0x08 | control |
| 0x0C | transmit data (write only) |
| 0x10 | status |
| 0x14 | receive data (read only) |
| 0x18 | queue control |
| 0x20 | port control |

Unmapped addresses read as 0.

Top module: `serial_reg_front`

## Requirements
- R1: The receive queue holds 16 bytes in arrival order. A byte that arrives while the queue already holds 16 is discarded.
- R2: Status bits are DR=0, RDF=1, BRK=4, TDE=5 and TEND=6. On a status write, each of these flags whose written bit is 0 is cleared. A written 1 leaves the flag as it was.
- R3: RDF sets when an accepted byte brings the count to or above the trigger level. It clears when a receive-data read leaves the count below the trigger level.
- R4: rx_irq rises when a push sets RDF while control bit 6 is 1. It falls on a status write with bit 1 or bit 0 at 0, and on a control write with bit 6 at 0.
- R5: Control bit 4 gates reception: bytes are accepted only while it is 1. Control bit 5 enables the transmitter. tx_irq follows control bit 7.
- R6: The register write masks are 0xFA for control, 0x7B for mode and 0xF3 for port control. A control write with bit 5 at 0 sets TEND.
- R7: A write to offset 0x0C drives tx_valid high with tx_data equal to the written byte in the next cycle, and clears TDE.
- R8: A read of offset 0x14 returns the oldest queued byte and removes it. On an empty queue the read returns 0 and changes nothing.
- R9: While control bit 5 is 1, a status read returns the current flags and then sets TDE and TEND.
- R10: Queue-control bits 7:6 select the trigger level: 00=1, 01=4, 10=8 and 11=14 bytes. Writing 1 to queue-control bit 1 empties the queue. Bit 1 reads back as 0.
- R11: After reset the status reads 0x60 (TEND and TDE set), the control register reads 0x20, and tx_valid, rx_irq and tx_irq are 0.
- R12: A one-cycle pulse on brk_in sets BRK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| brk_in | input | 1 | Line-break pulse |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench fills the queue past 16 entries and drains it. A design that wraps its pointers wrongly, or accepts the seventeenth byte, would return the bytes out of order or return the dropped byte. It steps the count across each of the trigger levels (1, 4, 8 and 14), where a comparison that is off by one would raise RDF one byte early or late. The bench checks that a status read returns the old flags before re-arming them, so a design that re-arms first would never show a cleared TDE. It also reads an empty queue, drives bytes while reception is disabled, and clears individual flags with a zero bit. Each of these exposes a pointer that moves on an empty read, a gate that is ignored, or a clear that spreads to the wrong bit.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int OFF_MODE = 'h00;
    localparam int OFF_CTL  = 'h08;
    localparam int OFF_TXD  = 'h0C;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_RXD  = 'h14;
    localparam int OFF_QCTL = 'h18;
    localparam int OFF_PORT = 'h20;

    localparam logic [7:0] MASK_CTL  = 8'hFA;
    localparam logic [7:0] MASK_MODE = 8'h7B;
    localparam logic [7:0] MASK_PORT = 8'hF3;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

    function automatic int unsigned trig_level(input logic [1:0] code);
        unique case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] flags_to_byte(input flags_t f);
        return {1'b0, f.tend, f.tde, f.brk, 2'b00, f.rdf, f.dr};
    endfunction

endpackage

// File: rtl/ser_rx_queue.sv
module ser_rx_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_data = (count == '0) ? '0 : mem[rd_ptr];
endmodule

// File: rtl/ser_status.sv
module ser_status
    import ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic       st_rd,
    input  logic       ctl_wr,
    input  logic       txd_wr,
    input  logic [7:0] wdata,
    input  logic       tx_en,
    input  logic       rie,
    input  logic       brk_in,
    input  logic       push_ev,
    input  logic       pop_ev,
    input  logic       level_ok,
    output flags_t     flags,
    output logic       rx_irq
);
    flags_t nxt;
    logic   irq_nxt;

    always_comb begin
        nxt     = flags;
        irq_nxt = rx_irq;
        if (pop_ev && !level_ok) nxt.rdf = 1'b0;
        if (push_ev && level_ok) begin
            nxt.rdf = 1'b1;
            if (rie) irq_nxt = 1'b1;
        end
        if (brk_in) nxt.brk = 1'b1;
        if (txd_wr) nxt.tde = 1'b0;
        if (ctl_wr && !wdata[5]) nxt.tend = 1'b1;
        if (ctl_wr && !wdata[6]) irq_nxt = 1'b0;
        if (st_rd && tx_en) begin
            nxt.tde  = 1'b1;
            nxt.tend = 1'b1;
        end
        if (st_wr) begin
            if (!wdata[6]) nxt.tend = 1'b0;
            if (!wdata[5]) nxt.tde  = 1'b0;
            if (!wdata[4]) nxt.brk  = 1'b0;
            if (!wdata[1]) nxt.rdf  = 1'b0;
            if (!wdata[0]) nxt.dr   = 1'b0;
            if (!wdata[1] || !wdata[0]) irq_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
            rx_irq <= 1'b0;
        end else begin
            flags  <= nxt;
            rx_irq <= irq_nxt;
        end
    end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
    import ser_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              brk_in,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              rx_irq,
    output logic              tx_irq
);
    logic [7:0]       mode_q, ctl_q, qctl_q, port_q;
    logic [7:0]       head_byte, status_q;
    logic [CNT_W-1:0] fifo_cnt, cnt_next;
    logic             wr_mode, wr_ctl, wr_txd, wr_stat, wr_qctl, wr_port;
    logic             rd_stat, rd_rxd;
    logic             push_ev, pop_ev, flush, level_ok;
    flags_t           flags;

    assign wr_mode = bus_wr && bus_addr == ADDR_W'(OFF_MODE);
    assign wr_ctl  = bus_wr && bus_addr == ADDR_W'(OFF_CTL);
    assign wr_txd  = bus_wr && bus_addr == ADDR_W'(OFF_TXD);
    assign wr_stat = bus_wr && bus_addr == ADDR_W'(OFF_STAT);
    assign wr_qctl = bus_wr && bus_addr == ADDR_W'(OFF_QCTL);
    assign wr_port = bus_wr && bus_addr == ADDR_W'(OFF_PORT);
    assign rd_stat = bus_rd && bus_addr == ADDR_W'(OFF_STAT);
    assign rd_rxd  = bus_rd && bus_addr == ADDR_W'(OFF_RXD);

    assign flush   = wr_qctl && bus_wdata[1];
    assign push_ev = rx_valid && ctl_q[4] && fifo_cnt < CNT_W'(DEPTH) && !flush;
    assign pop_ev  = rd_rxd && fifo_cnt != '0 && !flush;
    assign cnt_next = fifo_cnt + CNT_W'(push_ev) - CNT_W'(pop_ev);
    assign level_ok = cnt_next >= CNT_W'(trig_level(qctl_q[7:6]));

    ser_rx_queue #(.DEPTH(DEPTH), .DW(8)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ev),
        .push_data (rx_data),
        .pop       (pop_ev),
        .flush     (flush),
        .head_data (head_byte),
        .count     (fifo_cnt)
    );

    ser_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_wr    (wr_stat),
        .st_rd    (rd_stat),
        .ctl_wr   (wr_ctl),
        .txd_wr   (wr_txd),
        .wdata    (bus_wdata),
        .tx_en    (ctl_q[5]),
        .rie      (ctl_q[6]),
        .brk_in   (brk_in),
        .push_ev  (push_ev),
        .pop_ev   (pop_ev),
        .level_ok (level_ok),
        .flags    (flags),
        .rx_irq   (rx_irq)
    );

    assign status_q = flags_to_byte(flags);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ctl_q    <= 8'h20;
            qctl_q   <= '0;
            port_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata & MASK_MODE;
            if (wr_ctl)  ctl_q  <= bus_wdata & MASK_CTL;
            if (wr_qctl) qctl_q <= bus_wdata & 8'hFD;
            if (wr_port) port_q <= bus_wdata & MASK_PORT;
            tx_valid <= wr_txd;
            if (wr_txd) tx_data <= bus_wdata;
        end
    end

    assign tx_irq = ctl_q[7];

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (int'(bus_addr))
                OFF_MODE: bus_rdata = mode_q;
                OFF_CTL:  bus_rdata = ctl_q;
                OFF_STAT: bus_rdata = status_q;
                OFF_RXD:  bus_rdata = head_byte;
                OFF_QCTL: bus_rdata = qctl_q;
                OFF_PORT: bus_rdata = port_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ser_front_chk.sv
module ser_front_chk #(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              brk_in,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic [7:0]        status_q,
    input logic [7:0]        ctl_q
);
    logic wr_ctl, wr_txd, wr_stat, flush_req, rd_any;
    assign wr_ctl    = bus_wr && bus_addr == ADDR_W'('h08);
    assign wr_txd    = bus_wr && bus_addr == ADDR_W'('h0C);
    assign wr_stat   = bus_wr && bus_addr == ADDR_W'('h10);
    assign flush_req = bus_wr && bus_addr == ADDR_W'('h18) && bus_wdata[1];
    assign rd_any    = bus_rd;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH) && !rd_any && !flush_req) |=> fifo_cnt == CNT_W'(DEPTH));

    p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bus_wdata[4] && !brk_in) |=> !status_q[4]);

    p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[6]) |=> !rx_irq);

    p_tx_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> tx_irq == $past(bus_wdata[7]));

    p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |=> fifo_cnt <= $past(fifo_cnt));

    p_tx_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> (tx_valid && tx_data == $past(bus_wdata)));

    p_tde_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && !rd_any) |=> !status_q[5]);
endmodule

bind serial_reg_front ser_front_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .brk_in    (brk_in),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_irq    (rx_irq),
    .tx_irq    (tx_irq),
    .fifo_cnt  (fifo_cnt),
    .status_q  (status_q),
    .ctl_q     (ctl_q)
);

// File: tb/tb_serial_reg_front.sv
module tb_serial_reg_front;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PUSH = 2'd2;
    localparam int NV = 26;
    // {op, addr, data, expected}
    localparam logic [23:0] VEC [NV] = '{
        {OP_RD,   6'h10, 8'h00, 8'h60},  // R11 reset flags
        {OP_RD,   6'h08, 8'h00, 8'h20},  // R11 reset control
        {OP_WR,   6'h08, 8'hFF, 8'h00},
        {OP_RD,   6'h08, 8'h00, 8'hFA},  // R6 control mask
        {OP_WR,   6'h00, 8'hFF, 8'h00},
        {OP_RD,   6'h00, 8'h00, 8'h7B},  // R6 mode mask
        {OP_WR,   6'h20, 8'hFF, 8'h00},
        {OP_RD,   6'h20, 8'h00, 8'hF3},  // R6 port mask
        {OP_WR,   6'h18, 8'h80, 8'h00},
        {OP_RD,   6'h18, 8'h00, 8'h80},  // R10 trigger code 10
        {OP_PUSH, 6'h00, 8'h11, 8'h00},
        {OP_PUSH, 6'h00, 8'h12, 8'h00},
        {OP_PUSH, 6'h00, 8'h13, 8'h00},
        {OP_PUSH, 6'h00, 8'h14, 8'h00},
        {OP_PUSH, 6'h00, 8'h15, 8'h00},
        {OP_PUSH, 6'h00, 8'h16, 8'h00},
        {OP_PUSH, 6'h00, 8'h17, 8'h00},
        {OP_RD,   6'h10, 8'h00, 8'h60},  // R3 seven below trigger 8
        {OP_PUSH, 6'h00, 8'h18, 8'h00},
        {OP_RD,   6'h10, 8'h00, 8'h62},  // R3 eight reaches trigger
        {OP_RD,   6'h14, 8'h00, 8'h11},  // R8 oldest byte
        {OP_RD,   6'h10, 8'h00, 8'h60},  // R3 pop below trigger
        {OP_WR,   6'h10, 8'hDF, 8'h00},
        {OP_RD,   6'h10, 8'h00, 8'h40},  // R2 only TDE cleared, R9 old value returned
        {OP_RD,   6'h10, 8'h00, 8'h60},  // R9 re-armed after read
        {OP_RD,   6'h14, 8'h00, 8'h12}   // R8 second byte
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0, brk_in = 1'b0;
    logic [7:0] bus_wdata = '0, rx_data = '0, bus_rdata, tx_data;
    logic       tx_valid, rx_irq, tx_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_reg_front dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .brk_in(brk_in),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge.
    task automatic bwr(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(req, bus_rdata, exp);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 tx_valid", {7'd0, tx_valid}, 8'h00);
        chk("R11 rx_irq", {7'd0, rx_irq}, 8'h00);
        chk("R11 tx_irq", {7'd0, tx_irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][23:22])
                OP_WR:   bwr(VEC[i][21:16], VEC[i][15:8]);
                OP_RD:   brd(VEC[i][21:16], VEC[i][7:0], $sformatf("table vector %0d", i));
                default: push(VEC[i][15:8]);
            endcase
        end

        // R4: queue holds 6, trigger 8, receive interrupt enabled
        push(8'h19); push(8'h1A);
        chk("R4 irq raised at trigger", {7'd0, rx_irq}, 8'h01);
        bwr(6'h10, 8'hFD);
        chk("R4 irq dropped by status write", {7'd0, rx_irq}, 8'h00);
        brd(6'h10, 8'h60, "R2 RDF cleared by zero bit");
        push(8'h1B);
        chk("R4 irq raised again", {7'd0, rx_irq}, 8'h01);
        bwr(6'h08, 8'hB0);
        chk("R4 irq dropped by control write", {7'd0, rx_irq}, 8'h00);
        chk("R5 tx_irq follows bit 7", {7'd0, tx_irq}, 8'h01);

        // R7 transmit
        bwr(6'h0C, 8'hA5);
        chk("R7 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R7 tx_data", tx_data, 8'hA5);
        @(negedge clk);
        chk("R7 tx_valid one cycle", {7'd0, tx_valid}, 8'h00);
        brd(6'h10, 8'h42, "R7 TDE cleared");

        // R10 flush, R1 fill past full, R8 drain and empty read
        bwr(6'h18, 8'h02);
        brd(6'h18, 8'h00, "R10 flush bit reads 0");
        brd(6'h14, 8'h00, "R10 queue empty after flush");
        for (int i = 0; i < 17; i++) push(8'h30 + 8'(i));
        for (int i = 0; i < 16; i++) brd(6'h14, 8'h30 + 8'(i), "R1 order after full");
        brd(6'h14, 8'h00, "R1 byte past full dropped, R8 empty read");
        brd(6'h14, 8'h00, "R8 empty read stays empty");

        // R10 trigger 14
        bwr(6'h18, 8'hC2); bwr(6'h10, 8'hFD);
        for (int i = 0; i < 13; i++) push(8'h50 + 8'(i));
        brd(6'h10, 8'h60, "R10 trigger 14 not reached at 13");
        push(8'h5D);
        brd(6'h10, 8'h62, "R10 trigger 14 reached");
        // R10 trigger 4
        bwr(6'h18, 8'h42); bwr(6'h10, 8'hFD);
        for (int i = 0; i < 3; i++) push(8'h60 + 8'(i));
        brd(6'h10, 8'h60, "R10 trigger 4 not reached at 3");
        push(8'h63);
        brd(6'h10, 8'h62, "R10 trigger 4 reached");

        // R5 reception disabled
        bwr(6'h08, 8'h20);
        chk("R5 tx_irq low", {7'd0, tx_irq}, 8'h00);
        bwr(6'h18, 8'h42); bwr(6'h10, 8'hFD);
        push(8'h77);
        brd(6'h14, 8'h00, "R5 byte ignored while disabled");
        brd(6'h10, 8'h60, "R5 RDF untouched while disabled");

        // R6 TEND set by control write, R9 no re-arm with transmitter off
        bwr(6'h08, 8'h00);
        bwr(6'h10, 8'h00);
        brd(6'h10, 8'h00, "R9 no re-arm with transmitter off");
        bwr(6'h08, 8'h10);
        brd(6'h10, 8'h40, "R6 TEND set by control write");

        // R12 break
        brk_in = 1'b1; @(negedge clk); brk_in = 1'b0;
        brd(6'h10, 8'h50, "R12 BRK set by pulse");
        bwr(6'h10, 8'hEF);
        brd(6'h10, 8'h40, "R2 BRK cleared alone");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule